// File: doc/BRIEF.md
# DDR Strobe-Clocked Read Capture

This block takes double-data-rate read data from an external memory and uses the memory's own data strobe, already delayed, as the capture clock. The strobe is inverted first. A rising edge of the inverted strobe is a falling edge of the original strobe, and it latches one beat. The opposite edge latches the other beat. A third register moves the falling-edge beat onto the rising edge, so each strobe cycle yields one pair of beats that are valid together.

Two output registers, clocked by a separate resynchronization clock, take that pair into the system domain. One output word carries the high half of the stream and the other carries the low half. The beat that arrives with a strobe rising edge goes to the low word. The beat that arrives with a strobe falling edge goes to the high word. The final beat of a burst comes with a strobe falling edge, and it is captured at that edge without waiting for a later one.

Top module: `ddr_read_capture`

## Requirements
- R1: While `rstN` is low, both output words read zero; the reset acts at once, without a clock edge.
- R2: A beat on `dqIn` at a falling edge of `strobeIn` (beats 1, 3, 5, ... of a burst counting from 0) appears on `beatHiOut` at the next rising edge of `resyncClk`.
- R3: A beat on `dqIn` at a rising edge of `strobeIn` (beats 0, 2, 4, ... of a burst) appears on `beatLoOut` at the rising edge of `resyncClk` that follows the next falling edge of `strobeIn`.
- R4: After each strobe cycle, the two output words show the same pair of beats at the same `resyncClk` edge: beat 2k+1 on `beatHiOut` and beat 2k on `beatLoOut`. Burst order is kept from one pair to the next.
- R5: The last beat of a burst is delivered even when the strobe stays low afterwards with no further edge.
- R6: While the strobe is idle, changes on `dqIn` have no effect, and both output words keep the last pair across any number of `resyncClk` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous active-low reset for all registers |
| strobeIn | input | 1 | Delayed data strobe from the memory, used as the capture clock |
| dqIn | input | DATA_W | Read data bus, one beat per strobe edge |
| resyncClk | input | 1 | Resynchronization clock of the receiving domain |
| beatHiOut | output | DATA_W | Beats captured on strobe falling edges, in the resync domain |
| beatLoOut | output | DATA_W | Beats captured on strobe rising edges, in the resync domain |

## Verification
The bench builds the block with `DATA_W` set to 16, twice the default. This lets beat values differ in every byte, so truncation, swapped halves or a beat taken from the wrong edge each give a mismatch. The bench sends 4-beat and 8-beat bursts back to back, one strobe cycle per resync cycle, with the strobe falling edge at a fixed offset before the resync edge. It then holds the strobe idle while it toggles the data bus, which exercises both the last-beat capture and the idle-hold behaviour.

// File: rtl/ddrcap_pkg.sv
package ddrcap_pkg;

  // Strobes handed from the strobe-control stage to the capture datapath.
  typedef struct packed {
    logic invStrobe;   // inverted data strobe; both edges are used
  } capStrobes_t;

  // Number of capture-domain registers per bit (odd, even, aligned).
  localparam int CAP_STAGES = 3;

endpackage

// File: rtl/strobe_ctrl.sv
module strobe_ctrl
  import ddrcap_pkg::*;
(
  input  logic        strobeIn,
  output capStrobes_t strobes
);

  // Inversion puts the final falling edge of a burst on a rising capture
  // edge, so the last beat is latched without a further strobe transition.
  always_comb begin
    strobes.invStrobe = ~strobeIn;
  end

endmodule

// File: rtl/capture_datapath.sv
module capture_datapath
  import ddrcap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              rstN,
  input  capStrobes_t       strobes,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] oddBeat,
  output logic [DATA_W-1:0] evenAligned
);

  localparam int TOTAL_BITS = DATA_W * CAP_STAGES;

  logic              capClk;
  logic [DATA_W-1:0] oddReg;
  logic [DATA_W-1:0] evenReg;
  logic [DATA_W-1:0] alignReg;

  assign capClk = strobes.invStrobe;

  // Rising edge of the inverted strobe: odd beat, and realign the even beat.
  always_ff @(posedge capClk or negedge rstN) begin
    if (!rstN) begin
      oddReg   <= '0;
      alignReg <= '0;
    end else begin
      oddReg   <= dqIn;
      alignReg <= evenReg;
    end
  end

  // Falling edge of the inverted strobe: even beat.
  always_ff @(negedge capClk or negedge rstN) begin
    if (!rstN) begin
      evenReg <= '0;
    end else begin
      evenReg <= dqIn;
    end
  end

  assign oddBeat     = oddReg;
  assign evenAligned = alignReg;

  // Edge-seen flags so the checks below only look back past a real edge.
  logic riseSeen;
  logic fallSeen;

  always_ff @(posedge capClk or negedge rstN) begin
    if (!rstN) riseSeen <= 1'b0;
    else       riseSeen <= 1'b1;
  end

  always_ff @(negedge capClk or negedge rstN) begin
    if (!rstN) fallSeen <= 1'b0;
    else       fallSeen <= 1'b1;
  end

  AST_ODD_TRACKS_DQ: assert property (@(posedge capClk) disable iff (!rstN)
    riseSeen |-> oddReg == $past(dqIn)); // R2

  AST_EVEN_TRACKS_DQ: assert property (@(negedge capClk) disable iff (!rstN)
    fallSeen |-> evenReg == $past(dqIn)); // R3

  AST_ALIGN_PAIR: assert property (@(posedge capClk) disable iff (!rstN)
    riseSeen |-> alignReg == $past(evenReg)); // R4

  initial begin
    assert (TOTAL_BITS == 3 * DATA_W && DATA_W > 0);
  end

endmodule

// File: rtl/resync_regs.sv
module resync_regs #(
  parameter int DATA_W = 8
) (
  input  logic              rstN,
  input  logic              resyncClk,
  input  logic [DATA_W-1:0] oddBeat,
  input  logic [DATA_W-1:0] evenAligned,
  output logic [DATA_W-1:0] beatHiOut,
  output logic [DATA_W-1:0] beatLoOut
);

  always_ff @(posedge resyncClk or negedge rstN) begin
    if (!rstN) begin
      beatHiOut <= '0;
      beatLoOut <= '0;
    end else begin
      beatHiOut <= oddBeat;
      beatLoOut <= evenAligned;
    end
  end

  AST_HI_HANDOFF: assert property (@(posedge resyncClk) disable iff (!rstN)
    $past(rstN) |-> beatHiOut == $past(oddBeat)); // R2

  AST_LO_HANDOFF: assert property (@(posedge resyncClk) disable iff (!rstN)
    $past(rstN) |-> beatLoOut == $past(evenAligned)); // R3

  AST_RESET_ZERO: assert property (@(posedge resyncClk)
    (!rstN && $past(!rstN)) |-> (beatHiOut == '0 && beatLoOut == '0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge resyncClk) disable iff (!rstN)
    ($past(rstN) && $stable(oddBeat) && $stable(evenAligned)) |=>
      ($stable(beatHiOut) && $stable(beatLoOut))); // R6

endmodule

// File: rtl/ddr_read_capture.sv
module ddr_read_capture
  import ddrcap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              rstN,
  input  logic              strobeIn,
  input  logic [DATA_W-1:0] dqIn,
  input  logic              resyncClk,
  output logic [DATA_W-1:0] beatHiOut,
  output logic [DATA_W-1:0] beatLoOut
);

  capStrobes_t       strobes;
  logic [DATA_W-1:0] oddBeat;
  logic [DATA_W-1:0] evenAligned;

  strobe_ctrl u_ctrl (
    .strobeIn (strobeIn),
    .strobes  (strobes)
  );

  capture_datapath #(.DATA_W(DATA_W)) u_cap (
    .rstN        (rstN),
    .strobes     (strobes),
    .dqIn        (dqIn),
    .oddBeat     (oddBeat),
    .evenAligned (evenAligned)
  );

  resync_regs #(.DATA_W(DATA_W)) u_sync (
    .rstN        (rstN),
    .resyncClk   (resyncClk),
    .oddBeat     (oddBeat),
    .evenAligned (evenAligned),
    .beatHiOut   (beatHiOut),
    .beatLoOut   (beatLoOut)
  );

endmodule

// File: tb/ddr_read_capture_tb_top.sv
module ddr_read_capture_tb_top;

  localparam int W = 16;

  logic         rstN;
  logic         strobeIn;
  logic [W-1:0] dqIn;
  logic         resyncClk;
  logic [W-1:0] beatHiOut;
  logic [W-1:0] beatLoOut;

  int checks = 0;
  int errors = 0;
  bit cmpOn  = 0;
  bit done   = 0;

  // Behavioural model: last beat seen at each strobe edge kind, and the
  // values expected on the outputs after each resync edge.
  logic [W-1:0] mdlOdd, mdlEven, expHi, expLo;
  logic [W-1:0] beats[$];

  ddr_read_capture #(.DATA_W(W)) dut_i (
    .rstN      (rstN),
    .strobeIn  (strobeIn),
    .dqIn      (dqIn),
    .resyncClk (resyncClk),
    .beatHiOut (beatHiOut),
    .beatLoOut (beatLoOut)
  );

  initial resyncClk = 1'b0;
  always #5 resyncClk = ~resyncClk;

  always @(posedge resyncClk or negedge rstN) begin
    if (!rstN) begin
      expHi = '0;
      expLo = '0;
    end else begin
      expHi = mdlOdd;
      expLo = mdlEven;
    end
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model.
  always @(negedge resyncClk) begin
    if (cmpOn && !done) begin
      check("R2", beatHiOut, expHi);
      check("R3", beatLoOut, expLo);
    end
  end

  // One burst, one strobe cycle per resync cycle; pair k is checked at the
  // resync edge after its strobe falling edge.
  task automatic runBurst();
    int n = beats.size();
    for (int p = 0; p < n / 2; p++) begin
      @(posedge resyncClk);
      if (p > 0) begin
        #1;
        check("R4", beatHiOut, beats[2*p-1]);
        check("R4", beatLoOut, beats[2*p-2]);
      end else #1;
      dqIn = beats[2*p];
      #1 strobeIn = 1'b1;
      #1 dqIn = beats[2*p+1];
      #1 strobeIn = 1'b0;
      mdlOdd  = beats[2*p+1];
      mdlEven = beats[2*p];
      #1 dqIn = ~beats[2*p+1];
    end
    @(posedge resyncClk);
    #1;
    check("R5", beatHiOut, beats[n-1]);
    check("R4", beatLoOut, beats[n-2]);
  endtask

  task automatic idleToggle(int cycles);
    logic [W-1:0] holdHi = beatHiOut;
    logic [W-1:0] holdLo = beatLoOut;
    for (int c = 0; c < cycles; c++) begin
      @(posedge resyncClk);
      #2 dqIn = W'(c * 16'h3C5A) ^ 16'h9E37;
      #3;
      check("R6", beatHiOut, holdHi);
      check("R6", beatLoOut, holdLo);
    end
  endtask

  initial begin
    rstN = 1'b1; strobeIn = 1'b0; dqIn = '0;
    mdlOdd = '0; mdlEven = '0;
    #2 rstN = 1'b0;
    #1 cmpOn = 1;
    check("R1", beatHiOut, '0);
    check("R1", beatLoOut, '0);
    repeat (3) @(posedge resyncClk);
    #1;
    check("R1", beatHiOut, '0);
    check("R1", beatLoOut, '0);
    @(negedge resyncClk);
    #1 rstN = 1'b1;

    // 4-beat burst with distinct bytes
    beats = {16'h1100, 16'h2211, 16'h3322, 16'h4433};
    runBurst();
    idleToggle(4);

    // 8-beat burst, computed pattern
    beats.delete();
    for (int i = 0; i < 8; i++) beats.push_back(W'(i * 16'h1357) ^ 16'hA5A5);
    runBurst();
    idleToggle(3);

    // 8-beat burst, alternating all-ones / all-zeros
    beats.delete();
    for (int i = 0; i < 8; i++) beats.push_back(i[0] ? 16'hFFFF : 16'h0000);
    runBurst();

    // back-to-back 4-beat burst with walking bits, then long idle
    beats.delete();
    for (int i = 0; i < 4; i++) beats.push_back(16'h0001 << (i * 4 + 1));
    runBurst();
    idleToggle(6);

    // reset while holding data: outputs clear at once
    @(negedge resyncClk);
    #2 rstN = 1'b0;
    #1;
    check("R1", beatHiOut, '0);
    check("R1", beatLoOut, '0);
    mdlOdd = '0; mdlEven = '0;
    repeat (2) @(posedge resyncClk);
    #1;
    check("R1", beatHiOut, '0);
    check("R1", beatLoOut, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule